// File: doc/BRIEF.md
# Prioritized External and Internal Interrupt Controller

This block gathers one non-maskable input, eight external request pins and a parameterised group of internal peripheral request lines, and produces one interrupt request with its vector number towards the CPU. Each external pin is synchronised and then sensed by a low level, a falling edge, a rising edge or either edge. A detected event latches into a per-pin status flag. Software clears that flag by reading it as 1 and then writing 0. An edge-sensed flag also clears when the CPU acknowledges its vector.

Every maskable source carries one priority bit that puts it at level 1 or level 0. A mode input picks how the CPU mask bits I and UI gate these levels. In mode 0, I alone blocks every maskable source. In mode 1, level-1 sources stay open while I is set and UI is clear. The non-maskable input ignores all masking and always wins. Sources at the same level are ordered by a fixed scheme: external pin 0 first, then up to pin 7, then internal line 0 and upwards.

Software reaches the block through a byte-wide register port. The sense selects sit at address 0 (pins 0 to 3) and address 1 (pins 4 to 7), with pin n using bits 2(n mod 4)+1 and 2(n mod 4). Enables are at address 2, status flags at address 3, external priority bits at address 4 and internal priority bits at address 5. Address 6 bit 0 selects the non-maskable edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The 2-bit sense field of each external pin selects 00 = low level, 01 = falling edge, 10 = rising edge, 11 = either edge. A pin change sets its flag on the third rising clock edge after the change. All sense fields read 0 after reset.
- R2: A flag is set by a detected event whatever the pin's enable bit (address 2, bit n) holds. An enable of 0 keeps the pin from requesting but leaves its flag set, and setting the enable later makes the pending flag request.
- R3: Writing 0 to a flag bit at address 3 clears it only if that bit was read as 1 at address 3 beforehand. Writing 0 without that read leaves the flag set.
- R4: Address 6 bit 0 selects the non-maskable input's active edge (0 = falling, 1 = rising). A detected edge requests vector 7 whatever the mode, I and UI, and wins over every other source. An acknowledge of vector 7 clears that request.
- R5: External pin n requests vector 16+n, and internal line k requests vector 24+k.
- R6: In mode 0 (ctrl_mode = 0), no maskable source requests while cpu_i = 1, and every maskable source may request while cpu_i = 0.
- R7: In mode 1, a level-0 source requests only when cpu_i = 0. A level-1 source also requests when cpu_i = 1 and cpu_ui = 0. No maskable source requests when both mask bits are 1.
- R8: A pending level-1 source wins over a pending level-0 source, with the priority bits at address 4 for the pins and at address 5 for the internal lines. Within one level the lowest-numbered pin wins, and any external pin beats any internal line.
- R9: irq_ack while irq_req is high clears the flag of the accepted source when that source is edge-sensed. A level-sensed pin held low stays pending with the same vector after the acknowledge.
- R10: After reset, irq_req is 0 and the enable, flag and priority registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, asynchronous |
| ext_pin | input | 8 | External request pins, asynchronous |
| int_req | input | N_INT | Internal peripheral requests, level, synchronous |
| ctrl_mode | input | 1 | 0 = single mask bit, 1 = three-level masking |
| cpu_i | input | 1 | CPU interrupt mask bit I |
| cpu_ui | input | 1 | CPU user mask bit UI (mode 1 only) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, arms flag clearing |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector number of the current winner |
| irq_ack | input | 1 | CPU acknowledge of irq_vec |

## Verification
A software flag clear and a fresh event on the same pin can fall in the same cycle, and so can an acknowledge and a level re-detection. The bench provokes the second case by holding a low-level pin low through an acknowledge. It then judges that the same vector is still requested afterwards, while an edge-sensed pin acknowledged the same way drops its request. The first case is guarded by an in-line property: the flag stays set unless a clear or an acknowledge actually applies, and a new event in the same cycle takes precedence over the clear.

// File: rtl/irqc_pkg.sv
// Package: shared widths, vector numbers and register addresses of the
// interrupt controller. Assumes a byte-wide register port.
package irqc_pkg;
    localparam int N_EXT    = 8;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 16;
    localparam int NMI_VEC  = 7;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_SENSE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_SENSE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLAG     = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRIO_EXT = 3'd4;
    localparam logic [ADDR_W-1:0] A_PRIO_INT = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd6;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_t;
endpackage

// File: rtl/irqc_line.sv
// Module: one request pin. A two-flop synchroniser, an edge or level
// detector against the previous synchronised sample, and a status flag.
// Assumes the pin idles high; the synchroniser resets to 1 so that reset
// itself never looks like a falling edge.
module irqc_line
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sense,
    input  logic       sw_clr,
    input  logic       ack_clr,
    output logic       flag
);
    logic s1, s2, prev;
    logic hit;
    logic edge_mode;

    // Synchronise the pin and keep the previous stable sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Decode the selected sensing condition.
    always_comb begin
        unique case (sense_t'(sense))
            SNS_LOW:  hit = !s2;
            SNS_FALL: hit = prev && !s2;
            SNS_RISE: hit = !prev && s2;
            SNS_BOTH: hit = prev ^ s2;
            default:  hit = 1'b0;
        endcase
    end

    assign edge_mode = (sense != SNS_LOW);

    // Status flag: a new event wins over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit || (flag && !sw_clr && !(ack_clr && edge_mode));
    end

    // R3: a set flag survives unless a clear really applies.
    a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !sw_clr && !ack_clr |=> flag);
    // R1: a low synchronised level in level mode sets the flag next cycle.
    a_r1_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SNS_LOW) && !s2 |=> flag);
    // R9: an acknowledged edge flag with no new event drops.
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr && edge_mode && !hit |=> !flag);
endmodule

// File: rtl/irqc_arbiter.sv
// Module: masking and priority resolution. The non-maskable request wins
// outright; otherwise accepted level-1 sources beat accepted level-0
// sources, and within a level the lowest index wins.
// Assumes req and lvl are already registered or synchronous.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  lvl,
    input  logic             ctrl_mode,
    input  logic             cpu_i,
    input  logic             cpu_ui,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    localparam int IDX_W = $clog2(NSRC);

    logic             acc0, acc1;
    logic             found0, found1;
    logic [IDX_W-1:0] pick0, pick1, pick;

    // Acceptance per level from the mode and the CPU mask bits.
    always_comb begin
        acc0 = !cpu_i;
        acc1 = ctrl_mode ? !(cpu_i && cpu_ui) : !cpu_i;
    end

    // Lowest-index accepted source within each level.
    always_comb begin
        found0 = 1'b0;
        found1 = 1'b0;
        pick0  = '0;
        pick1  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && !lvl[i] && acc0) begin
                found0 = 1'b1;
                pick0  = IDX_W'(i);
            end
            if (req[i] && lvl[i] && acc1) begin
                found1 = 1'b1;
                pick1  = IDX_W'(i);
            end
        end
    end

    // Final winner and its vector number.
    always_comb begin
        pick    = found1 ? pick1 : pick0;
        irq_req = nmi || found0 || found1;
        irq_vec = nmi ? VEC_W'(NMI_VEC) : (VEC_W'(VEC_BASE) + VEC_W'(pick));
    end

    // R6: in mode 0 the I bit closes every maskable source.
    a_r6_mode0_block: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_mode && cpu_i && !nmi |-> !irq_req);
    // R7: in mode 1 both mask bits set close every maskable source.
    a_r7_mode1_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_mode && cpu_i && cpu_ui && !nmi |-> !irq_req);
    // R4: the non-maskable request always owns the output.
    a_r4_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> irq_req && (irq_vec == VEC_W'(NMI_VEC)));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the interrupt controller. Holds the byte-wide register
// file, one detector per external pin plus one for the non-maskable input,
// and the arbiter. Flags clear by read-1-then-write-0 or, for edge-sensed
// sources, by an acknowledge of their vector.
// Assumes N_INT <= 8 so the internal priority bits fit one byte.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N_INT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [N_INT-1:0]  int_req,
    input  logic              ctrl_mode,
    input  logic              cpu_i,
    input  logic              cpu_ui,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack
);
    localparam int NSRC = N_EXT + N_INT;

    logic [7:0]       sense_lo, sense_hi;
    logic [N_EXT-1:0] en, prio_ext, flags, seen, sw_clr, ack_hit;
    logic [N_INT-1:0] prio_int;
    logic             nmi_rise, nmi_flag, nmi_ack;
    logic [15:0]      sense_all;
    logic             flag_wr, flag_rd;

    assign sense_all = {sense_hi, sense_lo};
    assign flag_wr   = reg_wr && (reg_addr == A_FLAG);
    assign flag_rd   = reg_rd && (reg_addr == A_FLAG);
    assign sw_clr    = flag_wr ? (~reg_wdata & seen) : '0;

    // Software-visible control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_lo <= '0;
            sense_hi <= '0;
            en       <= '0;
            prio_ext <= '0;
            prio_int <= '0;
            nmi_rise <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_SENSE_LO: sense_lo <= reg_wdata;
                A_SENSE_HI: sense_hi <= reg_wdata;
                A_ENABLE:   en       <= reg_wdata;
                A_PRIO_EXT: prio_ext <= reg_wdata;
                A_PRIO_INT: prio_int <= reg_wdata[N_INT-1:0];
                A_CTRL:     nmi_rise <= reg_wdata[0];
                default:    ;
            endcase
        end
    end

    // Arming of flag clears: bits read as 1 may be cleared by a 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen <= '0;
        else if (flag_wr) seen <= seen & reg_wdata;
        else if (flag_rd) seen <= seen | flags;
    end

    // Register read mux.
    always_comb begin
        unique case (reg_addr)
            A_SENSE_LO: reg_rdata = sense_lo;
            A_SENSE_HI: reg_rdata = sense_hi;
            A_ENABLE:   reg_rdata = en;
            A_FLAG:     reg_rdata = flags;
            A_PRIO_EXT: reg_rdata = prio_ext;
            A_PRIO_INT: reg_rdata = 8'(prio_int);
            A_CTRL:     reg_rdata = {7'd0, nmi_rise};
            default:    reg_rdata = '0;
        endcase
    end

    // One detector per external pin.
    for (genvar n = 0; n < N_EXT; n++) begin : g_line
        assign ack_hit[n] = irq_ack && irq_req && (irq_vec == VEC_W'(VEC_BASE + n));
        irqc_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (ext_pin[n]),
            .sense   (sense_all[2*n +: 2]),
            .sw_clr  (sw_clr[n]),
            .ack_clr (ack_hit[n]),
            .flag    (flags[n])
        );
    end

    assign nmi_ack = irq_ack && irq_req && (irq_vec == VEC_W'(NMI_VEC));

    // Non-maskable input: the same detector, edge fixed by nmi_rise.
    irqc_line u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (nmi_pin),
        .sense   ({nmi_rise, !nmi_rise}),
        .sw_clr  (1'b0),
        .ack_clr (nmi_ack),
        .flag    (nmi_flag)
    );

    irqc_arbiter #(.NSRC(NSRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi       (nmi_flag),
        .req       ({int_req, flags & en}),
        .lvl       ({prio_int, prio_ext}),
        .ctrl_mode (ctrl_mode),
        .cpu_i     (cpu_i),
        .cpu_ui    (cpu_ui),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    // R5: any maskable winner carries a vector inside its source range.
    a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && (irq_vec != VEC_W'(NMI_VEC)) |->
        (irq_vec >= VEC_W'(VEC_BASE)) && (irq_vec < VEC_W'(VEC_BASE + NSRC)));
    // R2: nothing enabled, nothing internal, no NMI means no request.
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en) == '0) && (int_req == '0) && !nmi_flag |-> !irq_req);
endmodule

// File: tb/test_irq_prio_ctrl.sv
// Bench: table of internal-request masking cases, then directed tests of
// pin sensing, flag clearing, enable, order, acknowledge and NMI.
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b1;
    logic [7:0] ext_pin = 8'hFF;
    logic [3:0] int_req = '0;
    logic       ctrl_mode = 1'b0, cpu_i = 1'b0, cpu_ui = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.N_INT(4)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .ext_pin(ext_pin),
        .int_req(int_req), .ctrl_mode(ctrl_mode), .cpu_i(cpu_i), .cpu_ui(cpu_ui),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    // {mode, i, ui, int_req[3:0], prio_int[3:0], exp_req, exp_vec[7:0]}
    localparam logic [19:0] TBL [10] = '{
        {1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000, 1'b1, 8'd24},  // R5 R6
        {1'b0, 1'b1, 1'b0, 4'b0001, 4'b0000, 1'b0, 8'd0},   // R6
        {1'b0, 1'b0, 1'b0, 4'b1010, 4'b1000, 1'b1, 8'd27},  // R8
        {1'b0, 1'b0, 1'b0, 4'b1010, 4'b0000, 1'b1, 8'd25},  // R8
        {1'b1, 1'b1, 1'b0, 4'b0011, 4'b0010, 1'b1, 8'd25},  // R7
        {1'b1, 1'b1, 1'b0, 4'b0011, 4'b0000, 1'b0, 8'd0},   // R7
        {1'b1, 1'b1, 1'b1, 4'b1111, 4'b1111, 1'b0, 8'd0},   // R7
        {1'b1, 1'b0, 1'b1, 4'b1100, 4'b0100, 1'b1, 8'd26},  // R7 R8
        {1'b0, 1'b1, 1'b0, 4'b1111, 4'b1111, 1'b0, 8'd0},   // R6
        {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 8'd0}    // R6
    };

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] t;
        rd(3'd3, t);
        wr(3'd3, 8'h00);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 R1: reset state
        check("R10 irq_req after reset", irq_req, 0);
        rd(3'd0, d); check("R1 sense lo reset", d, 0);
        rd(3'd1, d); check("R1 sense hi reset", d, 0);
        rd(3'd2, d); check("R10 enable reset", d, 0);
        rd(3'd3, d); check("R10 flag reset", d, 0);
        rd(3'd4, d); check("R10 prio reset", d, 0);

        // Table of internal masking and ordering cases
        for (int k = 0; k < 10; k++) begin
            wr(3'd5, {4'd0, TBL[k][12:9]});
            ctrl_mode = TBL[k][19]; cpu_i = TBL[k][18]; cpu_ui = TBL[k][17];
            int_req = TBL[k][16:13];
            @(negedge clk);
            check($sformatf("R6 R7 R8 table %0d req", k), irq_req, TBL[k][8]);
            if (TBL[k][8]) check($sformatf("R5 R8 table %0d vec", k), irq_vec, TBL[k][7:0]);
        end
        int_req = '0; ctrl_mode = 0; cpu_i = 0; cpu_ui = 0;
        wr(3'd5, 8'h00);

        // R1: low level on pin 3, flag latches after release
        ext_pin[3] = 1'b0; settle(); ext_pin[3] = 1'b1; settle();
        rd(3'd3, d); check("R1 low level flag", d, 8'h08);
        wr(3'd3, 8'h00);
        rd(3'd3, d); check("R3 cleared after read", d, 8'h00);

        // R1: falling (pin0=01), rising (pin1=10), both (pin2=11)
        wr(3'd0, 8'b00_11_10_01);
        ext_pin[1] = 1'b0; settle();
        rd(3'd3, d); check("R1 rising ignores fall", d, 8'h00);
        ext_pin[0] = 1'b0; ext_pin[1] = 1'b1; settle();
        rd(3'd3, d); check("R1 falling and rising", d, 8'h03);
        wr(3'd3, 8'h00);
        ext_pin[2] = 1'b0; settle();
        rd(3'd3, d); check("R1 both edges fall", d, 8'h04);
        wr(3'd3, 8'h00);
        ext_pin[2] = 1'b1; settle();
        rd(3'd3, d); check("R1 both edges rise", d, 8'h04);
        ext_pin[0] = 1'b1; settle();

        // R3: write 0 without a prior read keeps the flag
        clear_flags();
        ext_pin[2] = 1'b0; settle();
        wr(3'd3, 8'h00);
        rd(3'd3, d); check("R3 unread flag kept", d, 8'h04);
        wr(3'd3, 8'h00);
        rd(3'd3, d); check("R3 read then clear", d, 8'h00);

        // R2: enable masks request but keeps the flag
        ext_pin[2] = 1'b1; settle(); clear_flags();
        ext_pin[2] = 1'b0; settle();
        check("R2 disabled no request", irq_req, 0);
        wr(3'd2, 8'h04);
        check("R2 enabled request", irq_req, 1);
        check("R5 pin 2 vector", irq_vec, 18);

        // R8: pin 5 as well, then priority on pin 5
        wr(3'd1, 8'b00_00_01_00);
        ext_pin[5] = 1'b0; settle();
        wr(3'd2, 8'h24);
        check("R8 lower pin wins", irq_vec, 18);
        wr(3'd4, 8'h20);
        check("R8 level 1 wins", irq_vec, 21);
        wr(3'd4, 8'h00);
        int_req = 4'b0001;
        @(negedge clk);
        check("R8 external before internal", irq_vec, 18);
        int_req = '0;

        // R9: acknowledge clears edge flags
        ack();
        check("R9 ack edge pin 2", irq_vec, 21);
        ack();
        check("R9 ack edge pin 5 drops", irq_req, 0);

        // R9: level pin 4 held low stays pending after ack
        ext_pin[2] = 1'b1; ext_pin[5] = 1'b1;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h10);
        ext_pin[4] = 1'b0; settle();
        ack();
        @(negedge clk);
        check("R9 level stays req", irq_req, 1);
        check("R9 level stays vec", irq_vec, 20);
        ext_pin[4] = 1'b1; settle();
        clear_flags();
        wr(3'd2, 8'h00);
        check("R2 R9 released idle", irq_req, 0);

        // R4: NMI falling, fully masked CPU
        ctrl_mode = 1; cpu_i = 1; cpu_ui = 1;
        nmi_pin = 1'b0; settle();
        check("R4 nmi falling req", irq_req, 1);
        check("R4 nmi vector", irq_vec, 7);
        ack();
        check("R4 nmi ack clears", irq_req, 0);
        wr(3'd6, 8'h01);
        nmi_pin = 1'b1; settle();
        check("R4 nmi rising vector", irq_vec, 7);
        ack();
        nmi_pin = 1'b0; settle();
        check("R4 rising ignores fall", irq_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule